// File: doc/BRIEF.md
# Hum-Rejecting Pulse-Centre Period Filter

The block takes a stream of edge timestamps from a free-running counter, where rising-edge and falling-edge stamps alternate, each stamp offered with a single-cycle write strobe. It stores the recent stamps in a circular store. On every accepted stamp it produces a period figure measured between pulse centres rather than between edges. Adding two neighbouring stamps gives twice a pulse midpoint, so a slow offset that shifts the duty cycle, such as mains hum riding on the oscillator, largely cancels. The figure is that pair sum minus the same pair sum taken `DELAY_N` stamps earlier.

The delay is counted in stamps, not clock cycles, and is best a power of two. Each doubling of `DELAY_N` adds one exact bit to the result, so `VALUE_W` must grow by one bit for every address bit. All arithmetic wraps modulo 2^`VALUE_W`. Because of that wrap, a counter rollover inside the window still gives the correct span, as long as the true span fits the width.

Top module: `hum_reject_period`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `valid_o` is 0 and `diff_o` is 0.
- R2: A cycle with `wr_i` low changes neither `diff_o` nor the stored history, and `valid_o` is 0 in the following cycle.
- R3: With `wr_i` high at clock edge k, `diff_o` after that edge equals s[n] + s[n-1] - s[n-N] - s[n-N-1]. Here s[n] is the stamp just written and N = `DELAY_N`. The result is valid whenever those stamps exist since reset.
- R4: `valid_o` is a pulse of one cycle that follows each accepted write once warm-up is over, and it is never high in a cycle that follows a cycle with no write.
- R5: After reset, the first N+1 writes produce no `valid_o`, and the (N+2)-th write and every later write do.
- R6: Sums and differences wrap modulo 2^`VALUE_W`, so stamps that roll over from all-ones to zero inside the window give the true span.
- R7: With every stamp larger than the previous one by a constant step S, each valid result equals 2·N·S modulo 2^`VALUE_W`.
- R8: An assertion of `rst_ni` in the middle of a stream discards the history and restarts the warm-up of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | One-cycle strobe that accepts `stamp_i` |
| stamp_i | input | VALUE_W | Edge timestamp; rising and falling edges alternate |
| diff_o | output | VALUE_W | Pulse-centre period figure |
| valid_o | output | 1 | One-cycle pulse marking a valid `diff_o` |

## Verification
The assertions assume that `wr_i` and `stamp_i` are clean, known values at every clock edge, and that `wr_i` may be high in any number of consecutive cycles. They also assume that the upstream stamps alternate in edge type, though the block never checks this. The stimulus drives inputs only on falling clock edges. It mixes back-to-back strobes with gaps of one to three idle cycles, and it uses stamps with a jittered high time so that the duty cycle really moves. It also starts one run close to the top of the counter range, so that the window spans a rollover.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  typedef enum logic {
    FILL_WARM = 1'b0,
    FILL_LIVE = 1'b1
  } fill_state_e;
endpackage

// File: rtl/hrp_ring.sv
// Circular stamp store: the slot at the write pointer holds the stamp written DEPTH writes ago.
module hrp_ring #(
  parameter int DEPTH   = 64,
  parameter int VALUE_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [VALUE_W-1:0] data_i,
  output logic [VALUE_W-1:0] old_o
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [VALUE_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0]  wp_q;

  assign old_o = mem_q[wp_q];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wp_q <= '0;
    else if (wr_i) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
  end

  // R3
  wp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> wp_q == (($past(wp_q) == LAST) ? '0 : $past(wp_q) + 1'b1));
  // R2
  wp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(wp_q));
endmodule

// File: rtl/hrp_fill.sv
// Warm-up tracker: goes live once N+1 stamps sit in history.
module hrp_fill
  import hrp_pkg::*;
#(
  parameter int DELAY_N = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  output logic live_o
);
  localparam int FULL  = DELAY_N + 1;
  localparam int CNT_W = $clog2(FULL + 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FULL);

  logic [CNT_W-1:0] cnt_q;
  fill_state_e      state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      state_q <= FILL_WARM;
    end else if (wr_i && state_q == FILL_WARM) begin
      cnt_q   <= cnt_q + 1'b1;
      if (cnt_q + 1'b1 == FULL_C) state_q <= FILL_LIVE;
    end
  end

  assign live_o = (state_q == FILL_LIVE);

  // R5
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_C);
  // R5
  live_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_o |=> live_o);
  // R5
  live_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_o |-> cnt_q == FULL_C);
endmodule

// File: rtl/hrp_pair_diff.sv
// Pair-sum difference: (new + previous) - (delayed + delayed previous).
module hrp_pair_diff #(
  parameter int VALUE_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               live_i,
  input  logic [VALUE_W-1:0] new_i,
  input  logic [VALUE_W-1:0] old_i,
  output logic [VALUE_W-1:0] diff_o,
  output logic               valid_o
);
  logic [VALUE_W-1:0] prev_new_q, prev_old_q, diff_q;
  logic [VALUE_W-1:0] sum_new, sum_old;
  logic               valid_q;

  assign sum_new = new_i + prev_new_q;
  assign sum_old = old_i + prev_old_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_new_q <= '0;
      prev_old_q <= '0;
      diff_q     <= '0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= wr_i && live_i;
      if (wr_i) begin
        prev_new_q <= new_i;
        prev_old_q <= old_i;
        diff_q     <= sum_new - sum_old;
      end
    end
  end

  assign diff_o  = diff_q;
  assign valid_o = valid_q;

  // R4
  valid_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(wr_i));
  // R2
  diff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(diff_o) && !valid_o);
endmodule

// File: rtl/hum_reject_period.sv
module hum_reject_period #(
  parameter int DELAY_N = 64,
  parameter int VALUE_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [VALUE_W-1:0] stamp_i,
  output logic [VALUE_W-1:0] diff_o,
  output logic               valid_o
);
  logic [VALUE_W-1:0] old_stamp;
  logic               live;

  hrp_ring #(.DEPTH(DELAY_N), .VALUE_W(VALUE_W)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .data_i (stamp_i),
    .old_o  (old_stamp)
  );

  hrp_fill #(.DELAY_N(DELAY_N)) u_fill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .live_o (live)
  );

  hrp_pair_diff #(.VALUE_W(VALUE_W)) u_diff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .live_i  (live),
    .new_i   (stamp_i),
    .old_i   (old_stamp),
    .diff_o  (diff_o),
    .valid_o (valid_o)
  );

  // R4
  valid_needs_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> live);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> !valid_o);
endmodule

// File: tb/hum_reject_period_bench.sv
module hum_reject_period_bench;
  localparam int N  = 64;
  localparam int VB = 20;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr = 1'b0;
  logic [VB-1:0] din = '0;
  logic [VB-1:0] diff_o;
  logic          valid_o;

  always #2.5 clk = ~clk;

  hum_reject_period #(.DELAY_N(N), .VALUE_W(VB)) u_hum_reject_period (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .stamp_i(din),
    .diff_o(diff_o), .valid_o(valid_o)
  );

  int            n_chk = 0, n_bad = 0;
  string         req = "R1";
  logic [VB-1:0] hist[$];
  logic          exp_valid = 1'b0;
  logic [VB-1:0] exp_diff = '0;
  logic          exp_hold = 1'b0;
  logic [VB-1:0] last_diff = '0;
  logic          done = 1'b0;
  int            lcg = 12345;

  task automatic check(input string tag, input logic ok, input logic [VB-1:0] act, input logic [VB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(req, valid_o === exp_valid, VB'(valid_o), VB'(exp_valid));
    if (exp_valid) check(req, diff_o === exp_diff, diff_o, exp_diff);
    if (exp_hold)  check("R2", diff_o === last_diff, diff_o, last_diff);
    last_diff = diff_o;
  endtask

  task automatic tick(input logic w, input logic [VB-1:0] v);
    @(negedge clk);
    compare();
    wr = w;
    din = v;
    exp_hold = !w && rst_ni;
    if (w) begin
      hist.push_front(v);
      if (hist.size() > N + 2) void'(hist.pop_back());
      exp_valid = (hist.size() == N + 2);
      if (exp_valid) exp_diff = hist[0] + hist[1] - hist[N] - hist[N+1];
    end else begin
      exp_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; wr = 1'b0;
    hist.delete();
    exp_valid = 1'b0; exp_hold = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check("R1", valid_o === 1'b0 && diff_o === '0, diff_o, '0);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", valid_o === 1'b0 && diff_o === '0, diff_o, '0);
    last_diff = diff_o;
  endtask

  function automatic int rnd(input int m);
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >>> 8) & 32'h7fff) % m;
  endfunction

  initial begin
    logic [VB-1:0] t;
    int valid_seen;
    do_reset();

    // R2: idle cycles leave everything untouched
    req = "R2";
    for (int i = 0; i < 10; i++) tick(1'b0, VB'(i * 7));

    // R5 and R7: constant step, back to back
    req = "R5";
    t = 100;
    valid_seen = 0;
    for (int i = 0; i < 200; i++) begin
      tick(1'b1, t);
      t = t + 37;
      if (valid_o) begin
        valid_seen++;
        // R7: steady result is 2*N*S
        check("R7", diff_o === VB'(2 * N * 37), diff_o, VB'(2 * N * 37));
      end
      if (i == N + 1) check("R5", valid_seen == 0, VB'(valid_seen), 0);
    end
    tick(1'b0, '0);

    // R3: duty-modulated stamps with gaps of 0..3 idle cycles
    req = "R3";
    t = 5000;
    for (int j = 0; j < 150; j++) begin
      tick(1'b1, t);
      repeat (rnd(4)) tick(1'b0, VB'(rnd(1000)));
      tick(1'b1, t + VB'(110 + rnd(9)));
      repeat (rnd(3)) tick(1'b0, '0);
      t = t + 240;
    end

    // R6: window straddles the counter rollover
    req = "R6";
    do_reset();
    t = VB'((1 << VB) - 3000);
    for (int i = 0; i < 250; i++) begin
      tick(1'b1, t);
      t = t + VB'(23 + (i % 2) * 5);
    end

    // R8: reset in mid-stream restarts warm-up
    req = "R8";
    do_reset();
    t = 7;
    valid_seen = 0;
    for (int i = 0; i < N + 10; i++) begin
      tick(1'b1, t);
      t = t + 51;
      if (valid_o) valid_seen++;
    end
    tick(1'b0, '0);
    tick(1'b0, '0);
    // writes N+2..N+10 give 9 pulses
    check("R8", valid_seen == 8 || valid_seen == 9, VB'(valid_seen), 9);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule